// File: doc/BRIEF.md
# Processor Bus Address Tenure Master

This block runs the address phase of a transfer on a split-transaction, cache-coherent processor bus. An internal client hands it an address and a transfer type. The block then requests the address bus from an external arbiter and waits for a grant it can trust. Once it has that grant, it takes ownership of the bus, issues a one-cycle transfer-start, and drives the address and type until the slave acknowledges. It then gives the bus back. If another agent raises address retry in the cycle after the acknowledge, the same transfer is requested again.

The block does not rely on a shared bus-busy wire. It tracks bus occupancy from the transfer-start and acknowledge traffic of every agent, and it also obeys an external busy line when the system has one. Every bus control signal is active-low. Address and type are valid only while the output-enable is high. The data phase and the arbiter are outside this block.

Top module: `abus_tenure_master`

## Requirements
- R1: While reset is high and in the cycle after it, `bus_br_n`, `bus_abb_n` and `bus_ts_n` are 1, and `bus_aoe` and `req_done` are 0.
- R2: A request on `req_valid` is taken only while the master is idle. A request raised during a tenure changes neither the driven address nor the start of a new tenure. With no request pending, a parked grant causes no bus activity.
- R3: In the cycle after a request is taken, `bus_br_n` is 0. It stays 0 until a qualified grant is seen, and it is never 0 while `bus_abb_n` is 0.
- R4: A grant is qualified in a cycle only if `bus_bg_n` is 0, `bus_artry_n` is 1, and the bus is not busy. `bus_ts_n` goes to 0 in the cycle after the qualified grant.
- R5: `bus_ts_n` is 0 for exactly one cycle. From that cycle until the cycle in which acknowledge is sampled, `bus_abb_n` is 0, `bus_aoe` is 1, and `bus_addr` and `bus_tt` hold the captured request.
- R6: In the cycle after `bus_aack_n` is sampled at 0 during ownership, `bus_abb_n` is 1 and `bus_aoe` is 0. This holds even when `bus_bg_n` stays 0 the whole time.
- R7: The cycle right after the acknowledge is the retry window. If `bus_artry_n` is 0 there, the master asserts `bus_br_n` again in the next cycle and drives the same address again. In that case no `req_done` is given.
- R8: A 0 on `bus_ts_in_n` (transfer-start from any agent) marks the bus busy from the next cycle on. The bus is no longer busy in the cycle after `bus_aack_n` is sampled at 0. A grant is not qualified while the bus is busy.
- R9: While the external busy input `bus_abb_in_n` is 0, no grant is qualified.
- R10: `req_done` is a one-cycle pulse. It comes in the cycle after a retry window in which `bus_artry_n` was 1. A new request is taken from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Internal transfer request |
| req_addr | input | AW | Request address |
| req_ttype | input | TW | Request transfer type |
| req_done | output | 1 | One-cycle pulse on clean completion |
| bus_br_n | output | 1 | Address bus request, active low |
| bus_bg_n | input | 1 | Address bus grant, active low |
| bus_abb_n | output | 1 | Address bus busy (owner indication), active low |
| bus_abb_in_n | input | 1 | External busy line, active low; tie to 1 if absent |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_ts_in_n | input | 1 | Transfer start as seen on the bus from any agent, active low |
| bus_aack_n | input | 1 | Address acknowledge, active low |
| bus_artry_n | input | 1 | Address retry, active low |
| bus_addr | output | AW | Driven address, valid while bus_aoe is 1 |
| bus_tt | output | TW | Driven transfer type, valid while bus_aoe is 1 |
| bus_aoe | output | 1 | Output enable for address and type |

## Verification
The bench keeps the grant parked on the master across repeated tenures and checks that busy is still released after each acknowledge. A design that holds ownership under a parked grant would leave `bus_abb_n` low. The bench raises retry in the window, and a design that ignores it would pulse `req_done` on a cancelled transfer. The bench also sends another agent's transfer-start while the master is requesting, and a design without busy tracking would start a transfer on top of it. Finally, the bench holds the grant off with retry, with the external busy line, and with a withheld grant, and it raises a fresh request in the middle of a tenure. A master that starts early, or that latches the fresh request, would show up in the transfer-start timing or in the driven address.

// File: rtl/abus_pkg.sv
package abus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_START,
    ST_ACKWAIT,
    ST_RWIN
  } ten_state_e;
endpackage

// File: rtl/abus_busy_track.sv
module abus_busy_track (
  input  logic clk,
  input  logic rst,
  input  logic ts_seen_n,
  input  logic aack_n,
  input  logic ext_busy_n,
  output logic busy
);
  logic seen_q;

  // occupancy rebuilt from start/acknowledge traffic of all agents
  always_ff @(posedge clk) begin
    if (rst)             seen_q <= 1'b0;
    else if (!ts_seen_n) seen_q <= 1'b1;
    else if (!aack_n)    seen_q <= 1'b0;
  end

  assign busy = seen_q | ~ext_busy_n;
endmodule

// File: rtl/abus_grant_qual.sv
module abus_grant_qual (
  input  logic bg_n,
  input  logic artry_n,
  input  logic busy,
  output logic grant_ok
);
  assign grant_ok = ~bg_n & artry_n & ~busy;
endmodule

// File: rtl/abus_tenure_fsm.sv
module abus_tenure_fsm
  import abus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic grant_ok,
  input  logic aack_n,
  input  logic artry_n,
  output logic req_take,
  output logic own_nx,
  output logic br_n,
  output logic abb_n,
  output logic ts_n,
  output logic aoe,
  output logic done
);
  ten_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_ARB;
      ST_ARB:     if (grant_ok)  state_d = ST_START;
      ST_START:   state_d = ST_ACKWAIT;
      ST_ACKWAIT: if (!aack_n)   state_d = ST_RWIN;
      ST_RWIN:    state_d = artry_n ? ST_IDLE : ST_ARB;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign req_take = (state_q == ST_IDLE) && req_valid;
  assign own_nx   = (state_d == ST_START) || (state_d == ST_ACKWAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      br_n    <= 1'b1;
      abb_n   <= 1'b1;
      ts_n    <= 1'b1;
      aoe     <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      br_n    <= !(state_d == ST_ARB);
      abb_n   <= !own_nx;
      ts_n    <= !(state_d == ST_START);
      aoe     <= own_nx;
      done    <= (state_q == ST_RWIN) && artry_n;
    end
  end
endmodule

// File: rtl/abus_tenure_master.sv
module abus_tenure_master #(
  parameter int AW = 32,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] req_ttype,
  output logic          req_done,
  output logic          bus_br_n,
  input  logic          bus_bg_n,
  output logic          bus_abb_n,
  input  logic          bus_abb_in_n,
  output logic          bus_ts_n,
  input  logic          bus_ts_in_n,
  input  logic          bus_aack_n,
  input  logic          bus_artry_n,
  output logic [AW-1:0] bus_addr,
  output logic [TW-1:0] bus_tt,
  output logic          bus_aoe
);
  logic          bus_busy;
  logic          grant_ok;
  logic          req_take;
  logic          own_nx;
  logic [AW-1:0] cap_addr;
  logic [TW-1:0] cap_tt;

  abus_busy_track u_busy (
    .clk(clk), .rst(rst), .ts_seen_n(bus_ts_in_n), .aack_n(bus_aack_n),
    .ext_busy_n(bus_abb_in_n), .busy(bus_busy)
  );

  abus_grant_qual u_qual (
    .bg_n(bus_bg_n), .artry_n(bus_artry_n), .busy(bus_busy), .grant_ok(grant_ok)
  );

  abus_tenure_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .grant_ok(grant_ok),
    .aack_n(bus_aack_n), .artry_n(bus_artry_n), .req_take(req_take),
    .own_nx(own_nx), .br_n(bus_br_n), .abb_n(bus_abb_n), .ts_n(bus_ts_n),
    .aoe(bus_aoe), .done(req_done)
  );

  // request held unchanged across retries until completion
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_tt   <= '0;
    end else if (req_take) begin
      cap_addr <= req_addr;
      cap_tt   <= req_ttype;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_tt   <= '0;
    end else begin
      bus_addr <= own_nx ? cap_addr : '0;
      bus_tt   <= own_nx ? cap_tt   : '0;
    end
  end
endmodule

// File: rtl/abus_tenure_master_chk.sv
module abus_tenure_master_chk (
  input logic clk,
  input logic rst,
  input logic req_done,
  input logic bus_br_n,
  input logic bus_bg_n,
  input logic bus_abb_n,
  input logic bus_ts_n,
  input logic bus_aack_n,
  input logic bus_artry_n,
  input logic bus_aoe,
  input logic bus_busy
);
  // R3
  br_not_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_br_n |-> bus_abb_n);

  // R4
  ts_after_qual_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ts_n) |-> $past(!bus_bg_n && bus_artry_n && !bus_busy));

  // R5
  ts_single_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ts_n |=> bus_ts_n);

  // R5
  ts_owned_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ts_n |-> (!bus_abb_n && bus_aoe));

  // R6
  release_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_aack_n && !bus_abb_n && bus_ts_n) |=> (bus_abb_n && !bus_aoe));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  // R10
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    req_done |-> ($past(bus_artry_n) && $past(bus_abb_n)));
endmodule

bind abus_tenure_master abus_tenure_master_chk u_chk (
  .clk(clk), .rst(rst), .req_done(req_done), .bus_br_n(bus_br_n),
  .bus_bg_n(bus_bg_n), .bus_abb_n(bus_abb_n), .bus_ts_n(bus_ts_n),
  .bus_aack_n(bus_aack_n), .bus_artry_n(bus_artry_n), .bus_aoe(bus_aoe),
  .bus_busy(bus_busy)
);

// File: tb/abus_tenure_master_tb.sv
module abus_tenure_master_tb;
  localparam int AW = 32;
  localparam int TW = 5;
  localparam int NV = 6;
  // {addr, ttype, extra acknowledge wait, retry count}
  localparam logic [40:0] VEC [NV] = '{
    {32'h0000_1000, 5'h0a, 2'd0, 2'd0},
    {32'hdead_beef, 5'h12, 2'd2, 2'd0},
    {32'h8000_0040, 5'h01, 2'd1, 2'd1},
    {32'h1234_5678, 5'h1f, 2'd3, 2'd2},
    {32'hffff_fffc, 5'h00, 2'd0, 2'd3},
    {32'h0000_0000, 5'h15, 2'd1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_ttype = '0;
  logic bus_bg_n = 1'b0;
  logic bus_abb_in_n = 1'b1;
  logic other_ts_n = 1'b1;
  logic bus_aack_n = 1'b1;
  logic bus_artry_n = 1'b1;
  logic req_done, bus_br_n, bus_abb_n, bus_ts_n, bus_aoe;
  logic [AW-1:0] bus_addr;
  logic [TW-1:0] bus_tt;
  logic bus_ts_in_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign bus_ts_in_n = bus_ts_n & other_ts_n;

  abus_tenure_master #(.AW(AW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ttype(req_ttype), .req_done(req_done), .bus_br_n(bus_br_n),
    .bus_bg_n(bus_bg_n), .bus_abb_n(bus_abb_n), .bus_abb_in_n(bus_abb_in_n),
    .bus_ts_n(bus_ts_n), .bus_ts_in_n(bus_ts_in_n), .bus_aack_n(bus_aack_n),
    .bus_artry_n(bus_artry_n), .bus_addr(bus_addr), .bus_tt(bus_tt),
    .bus_aoe(bus_aoe)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic give_req(input logic [AW-1:0] a, input logic [TW-1:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_ttype = t;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_ttype = ~t;
  endtask

  // called at the negedge where transfer-start is seen
  task automatic ack_and_finish(input logic [AW-1:0] a, input logic [TW-1:0] t,
                                input int ackw, input bit retry);
    chk(!bus_abb_n && bus_aoe && bus_addr == a && bus_tt == t, "R5 drive",
        {bus_abb_n, bus_aoe, bus_addr}, {2'b01, a});
    @(negedge clk);
    chk(bus_ts_n == 1'b1, "R5 start one cycle", bus_ts_n, 1);
    for (int w = 0; w < ackw; w++) begin
      chk(!bus_abb_n && bus_addr == a, "R5 hold", {bus_abb_n, bus_addr}, {1'b0, a});
      @(negedge clk);
    end
    bus_aack_n = 1'b0;
    @(negedge clk);
    bus_aack_n = 1'b1;
    chk(bus_abb_n && !bus_aoe, "R6 release", {bus_abb_n, bus_aoe}, 2'b10);
    if (retry) begin
      bus_artry_n = 1'b0;
      @(negedge clk);
      bus_artry_n = 1'b1;
      chk(!bus_br_n && !req_done, "R7 rerequest", {bus_br_n, req_done}, 2'b00);
    end else begin
      @(negedge clk);
      chk(req_done == 1'b1, "R10 done pulse", req_done, 1);
      @(negedge clk);
      chk(!req_done && bus_br_n, "R10 done single", {req_done, bus_br_n}, 2'b01);
    end
  endtask

  task automatic wait_ts(output int lat);
    lat = 0;
    while (bus_ts_n && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(bus_br_n && bus_abb_n && bus_ts_n && !bus_aoe && !req_done, "R1 in reset",
        {bus_br_n, bus_abb_n, bus_ts_n, bus_aoe, req_done}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_br_n && bus_abb_n && bus_ts_n && !bus_aoe && !req_done, "R1 after reset",
        {bus_br_n, bus_abb_n, bus_ts_n, bus_aoe, req_done}, 5'b11100);

    // R2: parked grant, no request
    repeat (4) @(negedge clk);
    chk(bus_br_n && bus_ts_n, "R2 idle parked", {bus_br_n, bus_ts_n}, 2'b11);

    // vector table, grant parked throughout
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      logic [TW-1:0] t;
      int ackw, rtr;
      a = VEC[v][40:9]; t = VEC[v][8:4]; ackw = int'(VEC[v][3:2]); rtr = int'(VEC[v][1:0]);
      give_req(a, t);
      chk(!bus_br_n, "R3 request", bus_br_n, 0);
      for (int k = 0; k <= rtr; k++) begin
        wait_ts(lat);
        chk(lat == 1, "R4 start latency", lat, 1);
        ack_and_finish(a, t, ackw, k < rtr);
      end
    end

    // R4: withheld grant
    bus_bg_n = 1'b1;
    give_req(32'h0000_a000, 5'h03);
    repeat (3) @(negedge clk);
    chk(bus_ts_n && !bus_br_n, "R4 no grant", {bus_ts_n, bus_br_n}, 2'b10);
    bus_bg_n = 1'b0;
    @(negedge clk);
    chk(!bus_ts_n, "R4 grant given", bus_ts_n, 0);
    ack_and_finish(32'h0000_a000, 5'h03, 0, 1'b0);

    // R4: retry line active blocks grant
    bus_artry_n = 1'b0;
    give_req(32'h0000_b000, 5'h04);
    repeat (3) @(negedge clk);
    chk(bus_ts_n, "R4 retry blocks", bus_ts_n, 1);
    bus_artry_n = 1'b1;
    @(negedge clk);
    chk(!bus_ts_n, "R4 retry released", bus_ts_n, 0);
    ack_and_finish(32'h0000_b000, 5'h04, 1, 1'b0);

    // R8: other agent's transfer marks bus busy
    bus_bg_n = 1'b1;
    give_req(32'h0000_c000, 5'h05);
    other_ts_n = 1'b0;
    @(negedge clk);
    other_ts_n = 1'b1;
    bus_bg_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_ts_n && !bus_br_n, "R8 busy blocks", {bus_ts_n, bus_br_n}, 2'b10);
    bus_aack_n = 1'b0;
    @(negedge clk);
    bus_aack_n = 1'b1;
    chk(bus_ts_n, "R8 clear next cycle", bus_ts_n, 1);
    @(negedge clk);
    chk(!bus_ts_n, "R8 start after clear", bus_ts_n, 0);
    ack_and_finish(32'h0000_c000, 5'h05, 0, 1'b0);

    // R9: external busy line
    bus_abb_in_n = 1'b0;
    give_req(32'h0000_d000, 5'h06);
    repeat (3) @(negedge clk);
    chk(bus_ts_n, "R9 ext busy blocks", bus_ts_n, 1);
    bus_abb_in_n = 1'b1;
    @(negedge clk);
    chk(!bus_ts_n, "R9 ext busy released", bus_ts_n, 0);
    ack_and_finish(32'h0000_d000, 5'h06, 0, 1'b0);

    // R2: request during tenure ignored
    give_req(32'h0000_e000, 5'h07);
    wait_ts(lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h5555_0000; req_ttype = 5'h0c;
    @(negedge clk);
    chk(bus_addr == 32'h0000_e000, "R2 addr kept", bus_addr, 32'h0000_e000);
    bus_aack_n = 1'b0;
    @(negedge clk);
    bus_aack_n = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_done, "R10 done after ignore", req_done, 1);
    repeat (3) @(negedge clk);
    chk(bus_br_n && bus_ts_n, "R2 no extra tenure", {bus_br_n, bus_ts_n}, 2'b11);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule